// File: doc/BRIEF.md
# Configuration Header Responder

This block holds the 256-byte type-0 configuration header of one PCI function and answers a simple register bus. Each request carries a byte offset, an access size of 1, 2 or 4 bytes, a write flag and 32 bits of write data. The block answers exactly one cycle later with read data and an error flag. The identification, class, interrupt and base-address fields take their reset values from parameters. Only a few header fields accept writes, and which ones depends on the access width.

Six base-address registers (BARs) support the usual discovery handshake. Software writes all ones and reads back a size mask, then writes a base. The low type bits of every BAR survive every write. For each BAR the block drives a decoded base and a valid flag, and it pulses a one-cycle strobe whenever a BAR takes a new nonzero base. Any BAR can instead be tied to a fixed legacy I/O window. Such a BAR reads as zero, ignores writes and reports its fixed window as its decoded base.

Top module: `cfg_hdr_responder`

## Requirements
- R1: Every request cycle with `reqValid` high produces `rspValid` high in the next cycle and in no other cycle. A write returns `rspRdata` of zero. `rspErr` is low for sizes 1, 2 and 4.
- R2: A read of size N returns header bytes offset..offset+N-1 packed little-endian into the low bytes of `rspRdata`, with the upper bytes zero. The layout is: vendor 0x00, device 0x02, command 0x04, status 0x06, revision 0x08, class triple 0x09..0x0B, cache line 0x0C, latency timer 0x0D, header type 0x0E, BARs 0x10..0x27, subsystem vendor 0x2C, subsystem id 0x2E, interrupt line 0x3C, interrupt pin 0x3D. Reserved and unlisted bytes, and all bytes at 0x40 or above, read as zero.
- R3: A 1-byte write takes `reqWdata[7:0]`. It changes the header only at 0x3C (interrupt line), 0x0C (cache line size) or 0x0D (latency timer). A 1-byte write to any other offset has no effect.
- R4: A 2-byte write takes `reqWdata[15:0]`. It changes only the command register (0x04) or the status register (0x06). A 2-byte write to any other offset has no effect.
- R5: A 4-byte write acts only at a BAR offset 0x10+4n with n in 0..5. A 4-byte write to any other offset has no effect.
- R6: A 4-byte write of 0xFFFFFFFF to a BAR makes the BAR read back as ~(size-1) with its type bits replaced by the previous type bits. A size of zero therefore reads back as the type bits alone.
- R7: Any other BAR write stores the written data with the type bits cleared, ORed with the previous type bits. The type mask is bits [1:0] when bit 0 of the old value is 1 (I/O) and bits [3:0] otherwise (memory).
- R8: When a write under R7 leaves a nonzero base, the BAR's `barBase` slice takes that base (type bits cleared) and its `barValid` bit sets, in the response cycle. `rangeChanged` is high for exactly that cycle. A zero base or a sizing write leaves `barBase`, `barValid` and `rangeChanged` untouched.
- R9: A BAR marked in `LegacyMask` always reads as zero and ignores all writes. Its `barBase` is fixed at its reset value with the type bits cleared, and its `barValid` is always high.
- R10: An access size other than 1, 2 or 4 raises `rspErr` in the response cycle, returns `rspRdata` of zero and changes no state.
- R11: After reset, the command, status, cache line and latency fields read as zero. All other fields hold their parameter values. `barValid` is set only for legacy BARs, and `rangeChanged` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqOffset | input | 8 | Byte offset into the header |
| reqSize | input | 3 | Access size in bytes |
| reqWdata | input | 32 | Write data, right-aligned |
| rspValid | output | 1 | Response present (one cycle after request) |
| rspErr | output | 1 | Bad access size |
| rspRdata | output | 32 | Read data, little-endian |
| barBase | output | 192 | Decoded base of BAR n in bits [32n+31:32n] |
| barValid | output | 6 | Decoded base of BAR n is valid |
| rangeChanged | output | 1 | One-cycle pulse on a new BAR base |

## Verification
The BAR logic is driven with four kinds of write, and each separates one rule from its neighbours. An all-ones write tests sizing against the programming path, and a base with nonzero low bits tests type preservation. A base that masks down to zero checks that no range change fires, and a write to the legacy BAR checks that it is ignored. The memory, prefetchable-memory, I/O and zero-size BARs show that the right type mask is chosen from the old value. Every whitelisted and non-whitelisted offset gets a write at each width, followed by a read through the bus, so an accepted write can be told apart from an ignored one. Unaligned, reserved and out-of-range reads, plus sizes 0 and 3, cover the edges of the read path and the reject path.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  // BAR count and header offsets are fixed by the header format.
  localparam int BarCount = 6;
  localparam int HdrBytes = 64;
  localparam int HdrIdxW = $clog2(HdrBytes);
  localparam logic [7:0] BarFirstOff = 8'h10;
  localparam logic [7:0] OffCommand = 8'h04;
  localparam logic [7:0] OffStatus = 8'h06;
  localparam logic [7:0] OffCacheLine = 8'h0C;
  localparam logic [7:0] OffLatTimer = 8'h0D;
  localparam logic [7:0] OffIntLine = 8'h3C;
  localparam logic [31:0] IoTypeMask = 32'h0000_0003;
  localparam logic [31:0] MemTypeMask = 32'h0000_000F;

  // Strobes from the decoder to the register datapath.
  typedef struct packed {
    logic rspEn;
    logic rdEn;
    logic sizeBad;
    logic wrIntLine;
    logic wrCacheLine;
    logic wrLatTimer;
    logic wrCommand;
    logic wrStatus;
    logic barSizing;
    logic [BarCount-1:0] barWr;
  } cfgStrb_t;
endpackage

// File: rtl/cfg_hdr_ctrl.sv
module cfg_hdr_ctrl
  import cfg_hdr_pkg::*;
(
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [7:0]  reqOffset,
  input  logic [2:0]  reqSize,
  input  logic [31:0] reqWdata,
  output cfgStrb_t    strb
);
  localparam logic [7:0] BarEndOff = BarFirstOff + 8'(4 * BarCount);

  logic sizeOk;
  logic wrAny;
  logic inBar;
  logic [7:0] barRel;

  assign sizeOk = (reqSize == 3'd1) || (reqSize == 3'd2) || (reqSize == 3'd4);
  assign wrAny = reqValid && reqWrite && sizeOk;
  assign barRel = reqOffset - BarFirstOff;
  assign inBar = (reqOffset >= BarFirstOff) && (reqOffset < BarEndOff) &&
                 (reqOffset[1:0] == 2'b00);

  always_comb begin
    strb = '0;
    strb.rspEn = reqValid;
    strb.rdEn = reqValid && !reqWrite && sizeOk;
    strb.sizeBad = reqValid && !sizeOk;
    strb.wrIntLine = wrAny && (reqSize == 3'd1) && (reqOffset == OffIntLine);
    strb.wrCacheLine = wrAny && (reqSize == 3'd1) && (reqOffset == OffCacheLine);
    strb.wrLatTimer = wrAny && (reqSize == 3'd1) && (reqOffset == OffLatTimer);
    strb.wrCommand = wrAny && (reqSize == 3'd2) && (reqOffset == OffCommand);
    strb.wrStatus = wrAny && (reqSize == 3'd2) && (reqOffset == OffStatus);
    strb.barSizing = (reqWdata == 32'hFFFF_FFFF);
    for (int b = 0; b < BarCount; b++) begin
      strb.barWr[b] = wrAny && (reqSize == 3'd4) && inBar && (barRel[7:2] == 6'(b));
    end
  end
endmodule

// File: rtl/cfg_hdr_datapath.sv
module cfg_hdr_datapath
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] VendorId = 16'hABCD,
  parameter logic [15:0] DeviceId = 16'h1234,
  parameter logic [7:0]  RevisionId = 8'h02,
  parameter logic [23:0] ClassTriple = 24'h020000,
  parameter logic [7:0]  HeaderKind = 8'h00,
  parameter logic [7:0]  IntLineInit = 8'h0B,
  parameter logic [7:0]  IntPinInit = 8'h01,
  parameter logic [15:0] SubsysVendor = 16'h5A5A,
  parameter logic [15:0] SubsysId = 16'h0001,
  parameter logic [BarCount*32-1:0] BarInitVec = {32'h1, 32'h0, 32'h3F1, 32'h8, 32'h1, 32'h0},
  parameter logic [BarCount*32-1:0] BarSizeVec = {32'h10, 32'h0, 32'h8, 32'h10000, 32'h100, 32'h1000},
  parameter logic [BarCount-1:0] LegacyMask = 6'b001000
) (
  input  logic        clk,
  input  logic        rstN,
  input  cfgStrb_t    strb,
  input  logic [7:0]  reqOffset,
  input  logic [2:0]  reqSize,
  input  logic [31:0] reqWdata,
  output logic        rspValid,
  output logic        rspErr,
  output logic [31:0] rspRdata,
  output logic [BarCount*32-1:0] barBase,
  output logic [BarCount-1:0] barValid,
  output logic        rangeChanged
);
  logic [15:0] cmdQ, statQ;
  logic [7:0]  cacheQ, latQ, intLineQ;
  logic [31:0] barRd [BarCount];
  logic [BarCount-1:0] barChg;
  logic [7:0]  hdr [HdrBytes];
  logic [31:0] rdWord;
  logic [8:0]  idx;

  // Scalar header fields
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ <= '0;
      statQ <= '0;
      cacheQ <= '0;
      latQ <= '0;
      intLineQ <= IntLineInit;
    end else begin
      if (strb.wrCommand) cmdQ <= reqWdata[15:0];
      if (strb.wrStatus) statQ <= reqWdata[15:0];
      if (strb.wrCacheLine) cacheQ <= reqWdata[7:0];
      if (strb.wrLatTimer) latQ <= reqWdata[7:0];
      if (strb.wrIntLine) intLineQ <= reqWdata[7:0];
    end
  end

  // One slice per BAR; the parameter picks a live or a legacy slice.
  for (genvar b = 0; b < BarCount; b++) begin : g_bar
    localparam logic [31:0] InitV = BarInitVec[b*32 +: 32];
    localparam logic [31:0] SizeV = BarSizeVec[b*32 +: 32];
    if (LegacyMask[b]) begin : g_legacy
      localparam logic [31:0] FixMask = InitV[0] ? IoTypeMask : MemTypeMask;
      logic unusedLegacy;
      assign unusedLegacy = strb.barWr[b];
      assign barRd[b] = '0;
      assign barChg[b] = 1'b0;
      assign barBase[b*32 +: 32] = InitV & ~FixMask;
      assign barValid[b] = 1'b1;
    end else begin : g_live
      logic [31:0] barQ, baseQ;
      logic        vldQ;
      logic [31:0] typeMask, rawNew, baseNew;
      assign typeMask = barQ[0] ? IoTypeMask : MemTypeMask;
      assign rawNew = strb.barSizing ? ~(SizeV - 32'd1) : reqWdata;
      assign baseNew = reqWdata & ~typeMask;
      assign barChg[b] = strb.barWr[b] && !strb.barSizing && (baseNew != '0);
      always_ff @(posedge clk) begin
        if (!rstN) begin
          barQ <= InitV;
          baseQ <= '0;
          vldQ <= 1'b0;
        end else if (strb.barWr[b]) begin
          barQ <= (rawNew & ~typeMask) | (barQ & typeMask);
          if (barChg[b]) begin
            baseQ <= baseNew;
            vldQ <= 1'b1;
          end
        end
      end
      assign barRd[b] = barQ;
      assign barBase[b*32 +: 32] = baseQ;
      assign barValid[b] = vldQ;
    end
  end

  // Flat byte view of the header
  always_comb begin
    for (int i = 0; i < HdrBytes; i++) hdr[i] = '0;
    hdr[0] = VendorId[7:0];
    hdr[1] = VendorId[15:8];
    hdr[2] = DeviceId[7:0];
    hdr[3] = DeviceId[15:8];
    hdr[4] = cmdQ[7:0];
    hdr[5] = cmdQ[15:8];
    hdr[6] = statQ[7:0];
    hdr[7] = statQ[15:8];
    hdr[8] = RevisionId;
    hdr[9] = ClassTriple[7:0];
    hdr[10] = ClassTriple[15:8];
    hdr[11] = ClassTriple[23:16];
    hdr[12] = cacheQ;
    hdr[13] = latQ;
    hdr[14] = HeaderKind;
    for (int b = 0; b < BarCount; b++) begin
      for (int k = 0; k < 4; k++) hdr[16 + 4*b + k] = barRd[b][8*k +: 8];
    end
    hdr[44] = SubsysVendor[7:0];
    hdr[45] = SubsysVendor[15:8];
    hdr[46] = SubsysId[7:0];
    hdr[47] = SubsysId[15:8];
    hdr[60] = intLineQ;
    hdr[61] = IntPinInit;
  end

  // Little-endian gather of up to four bytes
  always_comb begin
    rdWord = '0;
    idx = '0;
    for (int k = 0; k < 4; k++) begin
      idx = {1'b0, reqOffset} + 9'(k);
      if ((3'(k) < reqSize) && (idx < 9'(HdrBytes))) rdWord[8*k +: 8] = hdr[idx[HdrIdxW-1:0]];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspErr <= 1'b0;
      rspRdata <= '0;
      rangeChanged <= 1'b0;
    end else begin
      rspValid <= strb.rspEn;
      rspErr <= strb.sizeBad;
      rspRdata <= strb.rdEn ? rdWord : '0;
      rangeChanged <= |barChg;
    end
  end
endmodule

// File: rtl/cfg_hdr_responder.sv
module cfg_hdr_responder
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] VendorId = 16'hABCD,
  parameter logic [15:0] DeviceId = 16'h1234,
  parameter logic [7:0]  RevisionId = 8'h02,
  parameter logic [23:0] ClassTriple = 24'h020000,
  parameter logic [7:0]  HeaderKind = 8'h00,
  parameter logic [7:0]  IntLineInit = 8'h0B,
  parameter logic [7:0]  IntPinInit = 8'h01,
  parameter logic [15:0] SubsysVendor = 16'h5A5A,
  parameter logic [15:0] SubsysId = 16'h0001,
  parameter logic [BarCount*32-1:0] BarInitVec = {32'h1, 32'h0, 32'h3F1, 32'h8, 32'h1, 32'h0},
  parameter logic [BarCount*32-1:0] BarSizeVec = {32'h10, 32'h0, 32'h8, 32'h10000, 32'h100, 32'h1000},
  parameter logic [BarCount-1:0] LegacyMask = 6'b001000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [7:0]  reqOffset,
  input  logic [2:0]  reqSize,
  input  logic [31:0] reqWdata,
  output logic        rspValid,
  output logic        rspErr,
  output logic [31:0] rspRdata,
  output logic [BarCount*32-1:0] barBase,
  output logic [BarCount-1:0] barValid,
  output logic        rangeChanged
);
  cfgStrb_t strb;

  cfg_hdr_ctrl u_ctrl (
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqOffset(reqOffset),
    .reqSize(reqSize),
    .reqWdata(reqWdata),
    .strb(strb)
  );

  cfg_hdr_datapath #(
    .VendorId(VendorId), .DeviceId(DeviceId), .RevisionId(RevisionId),
    .ClassTriple(ClassTriple), .HeaderKind(HeaderKind),
    .IntLineInit(IntLineInit), .IntPinInit(IntPinInit),
    .SubsysVendor(SubsysVendor), .SubsysId(SubsysId),
    .BarInitVec(BarInitVec), .BarSizeVec(BarSizeVec), .LegacyMask(LegacyMask)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .reqOffset(reqOffset),
    .reqSize(reqSize),
    .reqWdata(reqWdata),
    .rspValid(rspValid),
    .rspErr(rspErr),
    .rspRdata(rspRdata),
    .barBase(barBase),
    .barValid(barValid),
    .rangeChanged(rangeChanged)
  );
endmodule

// File: rtl/cfg_hdr_responder_chk.sv
module cfg_hdr_responder_chk
  import cfg_hdr_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqWrite,
  input logic [2:0]  reqSize,
  input logic        rspValid,
  input logic        rspErr,
  input logic [31:0] rspRdata,
  input logic [BarCount*32-1:0] barBase,
  input logic [BarCount-1:0] barValid,
  input logic        rangeChanged
);
  logic badSize;
  assign badSize = !((reqSize == 3'd1) || (reqSize == 3'd2) || (reqSize == 3'd4));

  // R1
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R1
  no_stray_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  // R10
  bad_size_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && badSize) |=> (rspErr && rspRdata == 32'h0));

  // R8
  range_pulse_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    rangeChanged |-> $past(reqValid && reqWrite && reqSize == 3'd4));

  // R8
  base_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rangeChanged |-> $stable(barBase));

  // R9
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((~barValid & $past(barValid)) == '0));
endmodule

bind cfg_hdr_responder cfg_hdr_responder_chk u_chk (
  .clk(clk),
  .rstN(rstN),
  .reqValid(reqValid),
  .reqWrite(reqWrite),
  .reqSize(reqSize),
  .rspValid(rspValid),
  .rspErr(rspErr),
  .rspRdata(rspRdata),
  .barBase(barBase),
  .barValid(barValid),
  .rangeChanged(rangeChanged)
);

// File: tb/cfg_hdr_responder_test.sv
`timescale 1ns/1ps
module cfg_hdr_responder_test;
  localparam logic [191:0] TbBarInit = {32'h1, 32'h0, 32'h3F1, 32'h8, 32'h1, 32'h0};
  localparam logic [191:0] TbBarSize = {32'h10, 32'h0, 32'h8, 32'h10000, 32'h100, 32'h1000};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [7:0] reqOffset = '0;
  logic [2:0] reqSize = '0;
  logic [31:0] reqWdata = '0;
  logic rspValid, rspErr, rangeChanged;
  logic [31:0] rspRdata;
  logic [191:0] barBase;
  logic [5:0] barValid;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] d;
    logic        e;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];

  always #4 clk = ~clk;

  cfg_hdr_responder #(
    .VendorId(16'hABCD), .DeviceId(16'h1234), .RevisionId(8'h02),
    .ClassTriple(24'h020000), .HeaderKind(8'h00), .IntLineInit(8'h0B),
    .IntPinInit(8'h01), .SubsysVendor(16'h5A5A), .SubsysId(16'h0001),
    .BarInitVec(TbBarInit), .BarSizeVec(TbBarSize), .LegacyMask(6'b001000)
  ) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqOffset(reqOffset), .reqSize(reqSize), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspErr(rspErr), .rspRdata(rspRdata),
    .barBase(barBase), .barValid(barValid), .rangeChanged(rangeChanged)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Driver: one request, expected response pushed to the scoreboard
  task automatic xfer(input bit wr, input logic [7:0] off, input logic [2:0] sz,
                      input logic [31:0] d, input logic [31:0] expD, input bit expE, input string tag);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqOffset = off; reqSize = sz; reqWdata = d;
    expQ.push_back('{expD, expE, tag});
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] off, input logic [2:0] sz, input logic [31:0] expD, input string tag);
    xfer(1'b0, off, sz, 32'h0, expD, 1'b0, tag);
  endtask

  task automatic wr(input logic [7:0] off, input logic [2:0] sz, input logic [31:0] d, input string tag);
    xfer(1'b1, off, sz, d, 32'h0, 1'b0, tag);
  endtask

  // Monitor: pops the scoreboard whenever a response shows up
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && rspValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R1 unexpected response", {31'h0, rspErr, rspRdata}, 64'h0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(rspRdata == it.d && rspErr == it.e, it.tag,
                {31'h0, rspErr, rspRdata}, {31'h0, it.e, it.d});
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", 64'h0, 64'h0);
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R11 reset state, R9 legacy base
    check(!rspValid && !rangeChanged, "R11 idle after reset", {62'h0, rspValid, rangeChanged}, 64'h0);
    check(barValid == 6'b001000, "R11 R9 barValid reset", {58'h0, barValid}, 64'h08);
    check(barBase[3*32 +: 32] == 32'h3F0, "R9 legacy base", {32'h0, barBase[3*32 +: 32]}, 64'h3F0);
    check(barBase[0 +: 32] == 32'h0, "R11 bar0 base reset", {32'h0, barBase[0 +: 32]}, 64'h0);

    // R2 reads, aligned and unaligned
    rd(8'h00, 3'd4, 32'h1234ABCD, "R2 vendor/device");
    rd(8'h02, 3'd2, 32'h00001234, "R2 device");
    rd(8'h0B, 3'd1, 32'h00000002, "R2 class byte");
    rd(8'h08, 3'd4, 32'h02000002, "R2 rev/class");
    rd(8'h3C, 3'd4, 32'h0000010B, "R2 R11 interrupt bytes");
    rd(8'h01, 3'd2, 32'h000034AB, "R2 unaligned");
    rd(8'h2C, 3'd4, 32'h00015A5A, "R2 subsystem");
    rd(8'h34, 3'd4, 32'h0, "R2 reserved zero");
    rd(8'h80, 3'd4, 32'h0, "R2 beyond header");
    rd(8'h3E, 3'd4, 32'h0, "R2 tail past end");
    rd(8'h04, 3'd4, 32'h0, "R11 command/status zero");
    rd(8'h14, 3'd4, 32'h1, "R11 bar1 init");
    rd(8'h1C, 3'd4, 32'h0, "R9 legacy reads zero");

    // R3 byte writes
    wr(8'h3C, 3'd1, 32'hFFFFFF55, "R3 write int line");
    rd(8'h3C, 3'd1, 32'h55, "R3 int line written");
    wr(8'h0C, 3'd1, 32'h10, "R3 write cache line");
    wr(8'h0D, 3'd1, 32'h20, "R3 write latency");
    rd(8'h0C, 3'd2, 32'h2010, "R3 cache/latency written");
    wr(8'h3D, 3'd1, 32'hFF, "R3 write int pin");
    rd(8'h3D, 3'd1, 32'h01, "R3 int pin ignored");
    wr(8'h04, 3'd1, 32'hFF, "R3 byte to command");
    rd(8'h04, 3'd2, 32'h0, "R3 command byte ignored");

    // R4 two-byte writes
    wr(8'h04, 3'd2, 32'hAAAA0147, "R4 write command");
    wr(8'h06, 3'd2, 32'h0280, "R4 write status");
    rd(8'h04, 3'd4, 32'h02800147, "R4 command/status written");
    wr(8'h0C, 3'd2, 32'hBEEF, "R4 halfword to cache line");
    rd(8'h0C, 3'd1, 32'h10, "R4 cache line ignored");
    wr(8'h00, 3'd2, 32'h1111, "R4 halfword to vendor");
    rd(8'h00, 3'd2, 32'hABCD, "R4 vendor ignored");

    // R5 word writes outside BARs
    wr(8'h04, 3'd4, 32'h12345678, "R5 word to command");
    rd(8'h04, 3'd4, 32'h02800147, "R5 command word ignored");
    wr(8'h3C, 3'd4, 32'h12345678, "R5 word to int line");
    rd(8'h3C, 3'd1, 32'h55, "R5 int line word ignored");
    wr(8'h12, 3'd4, 32'h12345678, "R5 unaligned BAR offset");
    rd(8'h10, 3'd4, 32'h0, "R5 unaligned ignored");

    // R6 sizing
    wr(8'h10, 3'd4, 32'hFFFFFFFF, "R6 size bar0");
    check(!rangeChanged && barValid[0] == 1'b0, "R6 R8 sizing no range change",
          {62'h0, rangeChanged, barValid[0]}, 64'h0);
    rd(8'h10, 3'd4, 32'hFFFFF000, "R6 bar0 mask");
    wr(8'h14, 3'd4, 32'hFFFFFFFF, "R6 size bar1");
    rd(8'h14, 3'd4, 32'hFFFFFF01, "R6 bar1 io mask");
    wr(8'h18, 3'd4, 32'hFFFFFFFF, "R6 size bar2");
    rd(8'h18, 3'd4, 32'hFFFF0008, "R6 bar2 prefetch mask");
    wr(8'h20, 3'd4, 32'hFFFFFFFF, "R6 size bar4");
    rd(8'h20, 3'd4, 32'h0, "R6 zero-size bar");
    wr(8'h24, 3'd4, 32'hFFFFFFFF, "R6 size bar5");
    rd(8'h24, 3'd4, 32'hFFFFFFF1, "R6 bar5 io mask");
    wr(8'h1C, 3'd4, 32'hFFFFFFFF, "R9 size legacy");
    rd(8'h1C, 3'd4, 32'h0, "R9 legacy sizing ignored");

    // R7/R8 programming
    wr(8'h10, 3'd4, 32'h80000007, "R7 program bar0");
    check(rangeChanged == 1'b1, "R8 range pulse bar0", {63'h0, rangeChanged}, 64'h1);
    check(barBase[0 +: 32] == 32'h80000000 && barValid[0],
          "R8 bar0 decoded", {31'h0, barValid[0], barBase[0 +: 32]}, {31'h0, 1'b1, 32'h80000000});
    @(negedge clk);
    check(rangeChanged == 1'b0, "R8 pulse one cycle", {63'h0, rangeChanged}, 64'h0);
    rd(8'h10, 3'd4, 32'h80000000, "R7 bar0 type kept");
    wr(8'h14, 3'd4, 32'h0000C002, "R7 program bar1");
    check(barBase[32 +: 32] == 32'h0000C000 && rangeChanged,
          "R8 bar1 decoded", {31'h0, rangeChanged, barBase[32 +: 32]}, {31'h0, 1'b1, 32'hC000});
    rd(8'h14, 3'd4, 32'h0000C001, "R7 io type kept");
    wr(8'h18, 3'd4, 32'hE0000000, "R7 program bar2");
    rd(8'h18, 3'd4, 32'hE0000008, "R7 prefetch bit kept");
    check(barBase[64 +: 32] == 32'hE0000000, "R8 bar2 decoded", {32'h0, barBase[64 +: 32]}, 64'hE0000000);
    wr(8'h20, 3'd4, 32'h0000000F, "R8 zero base write");
    check(!rangeChanged && !barValid[4], "R8 zero base no update",
          {62'h0, rangeChanged, barValid[4]}, 64'h0);
    rd(8'h20, 3'd4, 32'h0, "R7 zero base reads zero");
    wr(8'h1C, 3'd4, 32'h12345000, "R9 program legacy");
    check(!rangeChanged && barBase[3*32 +: 32] == 32'h3F0, "R9 legacy write ignored",
          {31'h0, rangeChanged, barBase[3*32 +: 32]}, 64'h3F0);
    rd(8'h1C, 3'd4, 32'h0, "R9 legacy still zero");

    // R10 bad sizes
    xfer(1'b0, 8'h00, 3'd3, 32'h0, 32'h0, 1'b1, "R10 read size 3");
    xfer(1'b1, 8'h3C, 3'd0, 32'h77, 32'h0, 1'b1, "R10 write size 0");
    rd(8'h3C, 3'd1, 32'h55, "R10 no state change");
    xfer(1'b1, 8'h10, 3'd3, 32'h40000000, 32'h0, 1'b1, "R10 bar write size 3");
    check(!rangeChanged && barBase[0 +: 32] == 32'h80000000, "R10 bar untouched",
          {31'h0, rangeChanged, barBase[0 +: 32]}, 64'h80000000);
    rd(8'h10, 3'd4, 32'h80000000, "R10 bar0 unchanged");

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R1 all responses seen", 64'(expQ.size()), 64'h0);
    summary();
  end
endmodule